// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sits between the address phase of an external bus and the bus sequencer. It holds a small set of chip-select windows. Each window has a 4 KB-aligned start page, a logarithmic size code, an enable bit, a two-bit bus mode and a timing word. Every presented 24-bit address is compared against all windows at once. One registered cycle later, the block reports which chip select fires, which bus mode and timing word the sequencer must use, or a miss flag when nothing claims the address.

Software or a boot sequencer programs the windows through a narrow write port. Each write selects a window and one of its configuration words. A window is sized as 4 KB shifted left by its size code. Only the address bits above that size are compared. A start page that is not aligned to the window size therefore matches the aligned block that contains it. When windows overlap, the lowest-numbered window claims the address.

Top module: `addr_window_decoder`

## Requirements
- R1: After a synchronous reset every window is disabled and the outputs `cs_o`, `no_match_o`, `bus_mode_o`, `timing_o` and `valid_o` are all zero.
- R2: An enabled window with a legal size code n matches an address when address bits 23 down to 12+n equal the same bits of `{start_page, 12'h000}`. The lower bits are ignored, including the low bits of an unaligned start page.
- R3: Size code n (0 to 11) gives a window of 4 KB << n. Code 0 covers exactly one 4 KB page, and code 11 covers 8 MB, where only bit 23 is compared.
- R4: A window whose size code is 12 to 15 never matches, even when it is enabled.
- R5: A window whose enable bit is 0 never asserts its chip select.
- R6: When several windows match, only the lowest-numbered one asserts its bit of `cs_o`. At most one bit of `cs_o` is ever set.
- R7: For a valid lookup that no window matches, `no_match_o` is 1 and `cs_o` is zero. `no_match_o` and a set chip select never appear together.
- R8: On a hit, `bus_mode_o` and `timing_o` carry the winning window's bus mode and timing word. On a miss they are zero. The bus mode encoding is 0 = 8-bit separate address/data, 1 = 8-bit shared address/data, 2 = 16-bit separate, 3 = 16-bit shared.
- R9: A lookup presented with `addr_valid_i` high produces its result with `valid_o` high after exactly one clock edge. In a cycle where `valid_o` is low, all other outputs are zero.
- R10: A configuration write takes effect at the clock edge that accepts it. A lookup presented in the same cycle as the write still sees the old configuration, and the next lookup sees the new one.
- R11: `cfg_sel_i` selects the configuration word to write. 0 = base: `cfg_wdata_i[11:0]` is the start page and `[15:12]` is the size code. 1 = function: bit 0 is enable and bits 5:4 are the bus mode. 2 = timing: bits 14:0. 3 is a spare code, and a write with it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_win_i | input | 2 | Window index for the write |
| cfg_sel_i | input | 2 | Configuration word select |
| cfg_wdata_i | input | 16 | Configuration write data |
| addr_valid_i | input | 1 | Lookup request |
| addr_i | input | 24 | Bus address to decode |
| valid_o | output | 1 | Registered lookup result valid |
| cs_o | output | 4 | One-hot chip selects, bit i for window i |
| no_match_o | output | 1 | No enabled window matched |
| bus_mode_o | output | 2 | Bus mode of the winning window |
| timing_o | output | 15 | Timing word of the winning window |

## Verification
A configuration write and a lookup can land in the same cycle. This happens most sharply when the write changes the enable of the very window the lookup hits. The bench provokes this by disabling window 1 in the same cycle that it presents an address inside window 1. Its scoreboard model computes the expected result from the configuration held before the write, and applies the write only afterwards. The result must still show window 1's chip select, and the next lookup of the same address must report a miss.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  localparam int ADDR_W         = 24;
  localparam int PAGE_SHIFT     = 12;
  localparam int PAGE_W         = ADDR_W - PAGE_SHIFT;
  localparam int SIZE_W         = 4;
  localparam int SIZE_LAST      = 11;
  localparam int MODE_W         = 2;
  localparam int TIMING_W       = 15;
  localparam int CFG_DATA_W     = 16;

  typedef enum logic [MODE_W-1:0] {
    MODE_8_SEP    = 2'd0,
    MODE_8_SHARED = 2'd1,
    MODE_16_SEP   = 2'd2,
    MODE_16_SHARED = 2'd3
  } bus_mode_e;

  typedef enum logic [1:0] {
    CFG_BASE   = 2'd0,
    CFG_FUNC   = 2'd1,
    CFG_TIMING = 2'd2,
    CFG_SPARE  = 2'd3
  } cfg_word_e;

  typedef struct packed {
    logic [PAGE_W-1:0]   page;
    logic [SIZE_W-1:0]   size;
    logic                en;
    bus_mode_e           mode;
    logic [TIMING_W-1:0] timing;
  } win_cfg_t;
endpackage

// File: rtl/win_cfg_regs.sv
module win_cfg_regs
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      win_i,
  input  logic [1:0]            sel_i,
  input  logic [CFG_DATA_W-1:0] wdata_i,
  output win_cfg_t              cfg_o [NUM_WIN]
);
  logic unused_wdata_bits;
  assign unused_wdata_bits = ^{wdata_i[15], wdata_i[3:1], wdata_i[15:6]};

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic hit_w;
    assign hit_w = we_i && (win_i == IDX_W'(w));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_o[w] <= '0;
      end else if (hit_w) begin
        case (cfg_word_e'(sel_i))
          CFG_BASE: begin
            cfg_o[w].page <= wdata_i[PAGE_W-1:0];
            cfg_o[w].size <= wdata_i[PAGE_W +: SIZE_W];
          end
          CFG_FUNC: begin
            cfg_o[w].en   <= wdata_i[0];
            cfg_o[w].mode <= bus_mode_e'(wdata_i[5:4]);
          end
          CFG_TIMING: cfg_o[w].timing <= wdata_i[TIMING_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/win_match.sv
module win_match
  import addr_win_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  win_cfg_t          cfg_i,
  output logic              hit_o
);
  logic [PAGE_W-1:0] diff;
  logic [PAGE_W-1:0] care;
  logic              legal;

  assign legal = (cfg_i.size <= SIZE_W'(SIZE_LAST));
  assign diff  = addr_i[ADDR_W-1:PAGE_SHIFT] ^ cfg_i.page;

  // Compare only page bits at or above the size code.
  always_comb begin
    care = '0;
    for (int j = 0; j < PAGE_W; j++) begin
      care[j] = (j >= int'(cfg_i.size));
    end
  end

  assign hit_o = cfg_i.en && legal && ((diff & care) == '0);
endmodule

// File: rtl/win_priority.sv
module win_priority
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_i,
  input  logic [NUM_WIN-1:0]  hit_i,
  input  win_cfg_t            cfg_i [NUM_WIN],
  output logic                valid_o,
  output logic [NUM_WIN-1:0]  cs_o,
  output logic                no_match_o,
  output logic [MODE_W-1:0]   mode_o,
  output logic [TIMING_W-1:0] timing_o
);
  logic                found;
  logic [NUM_WIN-1:0]  cs_n;
  logic [MODE_W-1:0]   mode_n;
  logic [TIMING_W-1:0] timing_n;

  always_comb begin
    found    = 1'b0;
    cs_n     = '0;
    mode_n   = '0;
    timing_n = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (!found && hit_i[i]) begin
        found    = 1'b1;
        cs_n[i]  = 1'b1;
        mode_n   = cfg_i[i].mode;
        timing_n = cfg_i[i].timing;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o    <= 1'b0;
      cs_o       <= '0;
      no_match_o <= 1'b0;
      mode_o     <= '0;
      timing_o   <= '0;
    end else begin
      valid_o    <= valid_i;
      cs_o       <= valid_i ? cs_n : '0;
      no_match_o <= valid_i && !found;
      mode_o     <= valid_i ? mode_n : '0;
      timing_o   <= valid_i ? timing_n : '0;
    end
  end

  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(cs_o));
  // R6
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && hit_i[0]) |=> (cs_o[0] && $onehot(cs_o)));
  // R7
  miss_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (hit_i == '0)) |=> (no_match_o && (cs_o == '0)));
  // R7
  miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    no_match_o |-> (cs_o == '0));
  // R9
  result_lat_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (cs_o == '0 && !no_match_o && mode_o == '0 && timing_o == '0));
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we_i,
  input  logic [IDX_W-1:0]      cfg_win_i,
  input  logic [1:0]            cfg_sel_i,
  input  logic [CFG_DATA_W-1:0] cfg_wdata_i,
  input  logic                  addr_valid_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output logic                  valid_o,
  output logic [NUM_WIN-1:0]    cs_o,
  output logic                  no_match_o,
  output logic [MODE_W-1:0]     bus_mode_o,
  output logic [TIMING_W-1:0]   timing_o
);
  win_cfg_t           cfg [NUM_WIN];
  logic [NUM_WIN-1:0] hit;

  win_cfg_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we_i    (cfg_we_i),
    .win_i   (cfg_win_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    win_match u_match (
      .addr_i (addr_i),
      .cfg_i  (cfg[w]),
      .hit_o  (hit[w])
    );

    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (addr_valid_i && !cfg[w].en) |=> !cs_o[w]);
    // R4
    reserved_size_chk: assert property (@(posedge clk) disable iff (rst)
      (addr_valid_i && cfg[w].size > SIZE_W'(SIZE_LAST)) |=> !cs_o[w]);
  end

  win_priority #(.NUM_WIN(NUM_WIN)) u_prio (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (addr_valid_i),
    .hit_i      (hit),
    .cfg_i      (cfg),
    .valid_o    (valid_o),
    .cs_o       (cs_o),
    .no_match_o (no_match_o),
    .mode_o     (bus_mode_o),
    .timing_o   (timing_o)
  );
endmodule

// File: tb/addr_window_decoder_test.sv
`timescale 1ns/1ps
module addr_window_decoder_test;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_win = '0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        addr_valid = 1'b0;
  logic [23:0] addr = '0;
  logic        valid;
  logic [NW-1:0] cs;
  logic        no_match;
  logic [1:0]  bus_mode;
  logic [14:0] timing;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_window_decoder #(.NUM_WIN(NW)) uut (
    .clk(clk), .rst(rst),
    .cfg_we_i(cfg_we), .cfg_win_i(cfg_win), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .addr_valid_i(addr_valid), .addr_i(addr),
    .valid_o(valid), .cs_o(cs), .no_match_o(no_match),
    .bus_mode_o(bus_mode), .timing_o(timing)
  );

  // Reference model of the window configuration
  logic [11:0] m_page [NW];
  logic [3:0]  m_size [NW];
  logic        m_en   [NW];
  logic [1:0]  m_mode [NW];
  logic [14:0] m_tim  [NW];

  // Expected item: {cs, no_match, mode, timing}
  logic [NW+1+2+15-1:0] exp_q [$];
  string tag_q [$];

  function automatic logic [NW+1+2+15-1:0] predict(input logic [23:0] a);
    logic [NW-1:0] c = '0;
    logic [1:0] md = '0;
    logic [14:0] tm = '0;
    bit f = 0;
    for (int i = 0; i < NW; i++) begin
      if (!f && m_en[i] && m_size[i] <= 4'd11 &&
          ((({m_page[i], 12'h000} ^ a) >> (12 + int'(m_size[i]))) == 24'h0)) begin
        f = 1; c[i] = 1'b1; md = m_mode[i]; tm = m_tim[i];
      end
    end
    return {c, !f, md, tm};
  endfunction

  task automatic model_write(input logic [1:0] w, input logic [1:0] s, input logic [15:0] d);
    case (s)
      2'd0: begin m_page[w] = d[11:0]; m_size[w] = d[15:12]; end
      2'd1: begin m_en[w] = d[0]; m_mode[w] = d[5:4]; end
      2'd2: m_tim[w] = d[14:0];
      default: ;
    endcase
  endtask

  // One cycle of stimulus, driven after a falling edge.
  task automatic step(input bit we, input logic [1:0] w, input logic [1:0] s,
                      input logic [15:0] d, input bit lv, input logic [23:0] a,
                      input string tag);
    cfg_we = we; cfg_win = w; cfg_sel = s; cfg_wdata = d;
    addr_valid = lv; addr = a;
    if (lv) begin
      exp_q.push_back(predict(a));
      tag_q.push_back(tag);
    end
    if (we) model_write(w, s, d);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] w, input logic [1:0] s, input logic [15:0] d);
    step(1'b1, w, s, d, 1'b0, 24'h0, "");
  endtask

  task automatic look(input logic [23:0] a, input string tag);
    step(1'b0, 2'd0, 2'd0, 16'h0, 1'b1, a, tag);
  endtask

  // Monitor: pops expected results as the design produces them.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9: unexpected result valid, actual cs=%b, expected no result", cs);
        end else begin
          logic [NW+1+2+15-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({cs, no_match, bus_mode, timing} !== e) begin
            errors++;
            $display("FAIL %s: actual cs=%b nm=%b mode=%0d tim=%h, expected cs=%b nm=%b mode=%0d tim=%h",
                     t, cs, no_match, bus_mode, timing,
                     e[NW+17:18], e[17], e[16:15], e[14:0]);
          end
        end
      end else if (cs != '0 || no_match || bus_mode != '0 || timing != '0) begin
        checks++;
        errors++;
        $display("FAIL R9: idle outputs actual cs=%b nm=%b, expected all zero", cs, no_match);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      m_page[i] = '0; m_size[i] = '0; m_en[i] = 1'b0; m_mode[i] = '0; m_tim[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    checks++;
    if ({valid, cs, no_match, bus_mode, timing} !== '0) begin
      errors++;
      $display("FAIL R1: actual valid=%b cs=%b nm=%b, expected zero", valid, cs, no_match);
    end
    look(24'h000000, "R1");
    look(24'hFFFFFF, "R1");

    // Window 0: 1 MB at 0x100000, 16-bit separate, timing 0x1234
    wr(2'd0, 2'd0, 16'h8100);
    wr(2'd0, 2'd1, 16'h0021);
    wr(2'd0, 2'd2, 16'h1234);
    look(24'h100000, "R2");
    look(24'h1FFFFF, "R3");
    look(24'h200000, "R3");
    look(24'h0FFFFF, "R7");

    // Window 1: 64 KB at 0x180000, overlapped by window 0
    wr(2'd1, 2'd0, 16'h4180);
    wr(2'd1, 2'd1, 16'h0031);
    wr(2'd1, 2'd2, 16'h7FFF);
    look(24'h180010, "R6");

    // Window 2: enabled, reserved size code 12 at 0x000000
    wr(2'd2, 2'd0, 16'hC000);
    wr(2'd2, 2'd1, 16'h0001);
    look(24'h000123, "R4");

    // Window 3: 8 MB at 0x800000, 8-bit shared
    wr(2'd3, 2'd0, 16'hB800);
    wr(2'd3, 2'd1, 16'h0011);
    wr(2'd3, 2'd2, 16'h0055);
    look(24'hFFFFFF, "R3");
    look(24'h7FFFFF, "R3");

    // Spare word select must not change window 3
    wr(2'd3, 2'd3, 16'hFFFF);
    look(24'hFFFFFF, "R11");

    // Disable window 0: window 1 now wins inside the overlap
    wr(2'd0, 2'd1, 16'h0020);
    look(24'h180010, "R5");
    look(24'h1F0000, "R5");
    look(24'h180010, "R8");

    // Window 2: single 4 KB page at 0x345000
    wr(2'd2, 2'd0, 16'h0345);
    look(24'h345FFF, "R3");
    look(24'h346000, "R3");

    // Window 2: 8 KB with unaligned start page 0x347
    wr(2'd2, 2'd0, 16'h1347);
    look(24'h346000, "R2");
    look(24'h347ABC, "R2");
    look(24'h348000, "R2");

    // Write and lookup in the same cycle: old configuration applies
    step(1'b1, 2'd1, 2'd1, 16'h0030, 1'b1, 24'h180010, "R10");
    look(24'h180010, "R10");

    // Back-to-back and idle gaps
    step(1'b0, 2'd0, 2'd0, 16'h0, 1'b0, 24'h0, "");
    look(24'h346FFF, "R9");
    look(24'h900000, "R9");

    step(1'b0, 2'd0, 2'd0, 16'h0, 1'b0, 24'h0, "");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: actual %0d results missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule